// File: doc/BRIEF.md
# Register Redirection Table Loader

This block keeps a small list of vector-configuration entries, written one at a time through a configuration port. On request it expands that list into two per-register attribute tables of 32 slots each, one for the integer register bank and one for the floating-point register bank. Each entry names a register slot through its key and uses a type code to pick a bank. Each entry also carries three attributes: a vector flag, a packed-SIMD flag and a bank field. Instruction decode reads the tables through a lookup port. The port takes a bank select and a register index and answers in the same cycle.

A rebuild starts with a one-cycle pulse on `rebuild`. The block spends one cycle clearing a working copy of both tables. It then applies the sixteen entries one per cycle, lowest index first. The finished tables become visible to lookups only when `busy` falls, so decode never sees a half-built table. The entry list used by a rebuild is captured at the moment the rebuild is accepted. Configuration writes that land while a rebuild is running are stored, but they wait for the following rebuild.

Top module: `regmap_builder`

## Requirements
- R1: After reset `busy` is 0, every slot of both banks reads all-zero (enabled, vector, packed and bank all 0), and every stored entry is zero (type 0, key 0, all flags 0).
- R2: An entry whose 2-bit type code is 0 writes the integer table (looked up with `lk_fp`=0); type codes 1, 2 and 3 all write the floating-point table (`lk_fp`=1).
- R3: An entry writes exactly the slot whose index equals its 5-bit key. Slots that no entry names read all-zero after the rebuild.
- R4: A written slot holds the entry's vector flag, packed flag and 1-bit bank field exactly as written. Bank value 1 is reserved, and the block stores it unchanged.
- R5: Every slot written by a rebuild reads with its enabled bit set to 1.
- R6: A rebuild clears both tables first, so a slot written by an earlier rebuild but named by no entry of the current one reads all-zero afterwards.
- R7: Entries are applied in ascending index order. When several entries name the same slot of the same bank, the highest-indexed one determines the slot.
- R8: `busy` rises in the cycle after a `rebuild` pulse is sampled while idle and stays high for exactly 1 + 16 cycles.
- R9: While `busy` is high, lookups return the tables as they were before the rebuild. The new contents appear from the first cycle with `busy` low.
- R10: A configuration write sampled in the same cycle as the accepted trigger, or while `busy` is high, updates the stored entry. The running rebuild does not use it, and the next rebuild does.
- R11: A `rebuild` pulse sampled while `busy` is high is ignored: the running rebuild keeps its 17-cycle length and no second rebuild follows it.
- R12: The lookup outputs are a combinational function of `lk_fp` and `lk_idx` and reflect a new index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one entry of the configuration list |
| cfg_addr | input | 4 | Entry index to write |
| cfg_kind | input | 2 | Type code: 0 integer bank, nonzero floating-point bank |
| cfg_key | input | 5 | Register slot the entry targets |
| cfg_vec | input | 1 | Vector flag for the entry |
| cfg_pkd | input | 1 | Packed-SIMD flag for the entry |
| cfg_bank | input | 1 | Bank field (0 valid, 1 reserved) |
| rebuild | input | 1 | One-cycle pulse that starts a rebuild |
| busy | output | 1 | High while a rebuild is running |
| lk_fp | input | 1 | Lookup bank select: 0 integer, 1 floating-point |
| lk_idx | input | 5 | Lookup register index |
| lk_en | output | 1 | Slot enabled (redirected) |
| lk_vec | output | 1 | Slot vector flag |
| lk_pkd | output | 1 | Slot packed-SIMD flag |
| lk_bank | output | 1 | Slot bank field |

## Verification
The bench gives the same slot two entries of different index. A design that walks the list in the wrong order, or lets the first writer win, shows the lower entry's attributes. It uses every nonzero type code and both bank-field values, so a design that checks only one type bit or masks the reserved bank value returns the wrong bank or a wrong field. During each rebuild it probes lookups every cycle and writes entries mid-rebuild and in the trigger cycle. A design that builds in place exposes partial tables, and a design without a captured list picks up late entries a rebuild early. A second rebuild with different keys and a retrigger pulse shows stale slots a missing clear would leave behind and any length change a restart would cause.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

    localparam int KIND_W   = 2;
    localparam int KEY_W    = 5;
    localparam int NUM_REGS = 1 << KEY_W;
    localparam int NUM_BANKS = 2;

    // One configuration list entry
    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [KEY_W-1:0]  key;
        logic              vec;
        logic              pkd;
        logic              bank;
    } cfg_entry_t;

    // One per-register table slot
    typedef struct packed {
        logic en;
        logic vec;
        logic pkd;
        logic bank;
    } slot_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_APPLY = 2'd2
    } phase_t;

    // Nonzero type code selects the floating-point bank
    function automatic logic entry_is_fp(cfg_entry_t e);
        return e.kind != '0;
    endfunction

    function automatic slot_t entry_to_slot(cfg_entry_t e);
        slot_t s;
        s.en   = 1'b1;
        s.vec  = e.vec;
        s.pkd  = e.pkd;
        s.bank = e.bank;
        return s;
    endfunction

endpackage

// File: rtl/regmap_entry_store.sv
module regmap_entry_store
    import regmap_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int ADDR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  cfg_entry_t        wdata,
    input  logic              capture,
    input  logic [ADDR_W-1:0] rd_idx,
    output cfg_entry_t        rd_entry
);

    cfg_entry_t snap_vec [NUM_ENTRIES];

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        cfg_entry_t live_q;
        cfg_entry_t snap_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q <= '0;
                snap_q <= '0;
            end else begin
                if (we && waddr == ADDR_W'(i))
                    live_q <= wdata;
                // capture sees the value before a same-cycle write
                if (capture)
                    snap_q <= live_q;
            end
        end

        assign snap_vec[i] = snap_q;
    end

    assign rd_entry = snap_vec[rd_idx];

endmodule

// File: rtl/regmap_sequencer.sv
module regmap_sequencer
    import regmap_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int ADDR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_ENTRIES - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              capture,
    output logic              clr,
    output logic              apply_en,
    output logic              commit,
    output logic [ADDR_W-1:0] ptr
);

    phase_t phase_q;
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ptr_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    ptr_q <= '0;
                    if (start)
                        phase_q <= PH_CLEAR;
                end
                PH_CLEAR: begin
                    phase_q <= PH_APPLY;
                end
                PH_APPLY: begin
                    if (ptr_q == LAST) begin
                        phase_q <= PH_IDLE;
                        ptr_q   <= '0;
                    end else begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase_q != PH_IDLE);
    assign capture  = (phase_q == PH_IDLE) && start;
    assign clr      = (phase_q == PH_CLEAR);
    assign apply_en = (phase_q == PH_APPLY);
    assign commit   = apply_en && (ptr_q == LAST);
    assign ptr      = ptr_q;

endmodule

// File: rtl/regmap_slot_table.sv
module regmap_slot_table
    import regmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_idx,
    input  slot_t            wr_slot,
    input  logic             commit,
    input  logic [KEY_W-1:0] rd_idx,
    output slot_t            rd_slot
);

    slot_t live_vec [NUM_REGS];

    for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
        slot_t work_q;
        slot_t work_d;
        slot_t live_q;

        always_comb begin
            if (clr)
                work_d = '0;
            else if (wr_en && wr_idx == KEY_W'(s))
                work_d = wr_slot;
            else
                work_d = work_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                work_q <= '0;
                live_q <= '0;
            end else begin
                work_q <= work_d;
                // publish including the final entry's write
                if (commit)
                    live_q <= work_d;
            end
        end

        assign live_vec[s] = live_q;
    end

    assign rd_slot = live_vec[rd_idx];

endmodule

// File: rtl/regmap_builder.sv
module regmap_builder
    import regmap_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int ADDR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [KIND_W-1:0] cfg_kind,
    input  logic [KEY_W-1:0]  cfg_key,
    input  logic              cfg_vec,
    input  logic              cfg_pkd,
    input  logic              cfg_bank,
    input  logic              rebuild,
    output logic              busy,
    input  logic              lk_fp,
    input  logic [KEY_W-1:0]  lk_idx,
    output logic              lk_en,
    output logic              lk_vec,
    output logic              lk_pkd,
    output logic              lk_bank
);

    cfg_entry_t        wr_entry;
    cfg_entry_t        cur_entry;
    slot_t             cur_slot;
    logic              cur_fp;
    logic              capture;
    logic              clr;
    logic              apply_en;
    logic              commit;
    logic [ADDR_W-1:0] ptr;
    slot_t             bank_rd [NUM_BANKS];
    slot_t             lk_slot;

    assign wr_entry.kind = cfg_kind;
    assign wr_entry.key  = cfg_key;
    assign wr_entry.vec  = cfg_vec;
    assign wr_entry.pkd  = cfg_pkd;
    assign wr_entry.bank = cfg_bank;

    regmap_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .waddr    (cfg_addr),
        .wdata    (wr_entry),
        .capture  (capture),
        .rd_idx   (ptr),
        .rd_entry (cur_entry)
    );

    regmap_sequencer #(.NUM_ENTRIES(NUM_ENTRIES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (rebuild),
        .busy     (busy),
        .capture  (capture),
        .clr      (clr),
        .apply_en (apply_en),
        .commit   (commit),
        .ptr      (ptr)
    );

    assign cur_slot = entry_to_slot(cur_entry);
    assign cur_fp   = entry_is_fp(cur_entry);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = apply_en && (cur_fp == 1'(b));

        regmap_slot_table u_tbl (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .wr_en   (bank_wr),
            .wr_idx  (cur_entry.key),
            .wr_slot (cur_slot),
            .commit  (commit),
            .rd_idx  (lk_idx),
            .rd_slot (bank_rd[b])
        );
    end

    assign lk_slot = lk_fp ? bank_rd[1] : bank_rd[0];
    assign lk_en   = lk_slot.en;
    assign lk_vec  = lk_slot.vec;
    assign lk_pkd  = lk_slot.pkd;
    assign lk_bank = lk_slot.bank;

endmodule

// File: rtl/regmap_builder_chk.sv
module regmap_builder_chk
    import regmap_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int ADDR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             rebuild,
    input logic             busy,
    input logic             lk_fp,
    input logic [KEY_W-1:0] lk_idx,
    input logic             lk_en,
    input logic             lk_vec,
    input logic             lk_pkd,
    input logic             lk_bank
);

    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= 0;
        else if (busy)
            run_q <= run_q + 1;
        else
            run_q <= 0;
    end

    // R8: length of a rebuild, counted instead of a long delay
    p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_q == NUM_ENTRIES + 1);

    // R8: an accepted trigger raises busy on the next cycle
    p_start_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && rebuild) |=> busy);

    // R11: busy only rises after a trigger
    p_rise_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(rebuild));

    // R9: published contents hold still while building
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || !$stable(lk_fp) || !$stable(lk_idx)
                  || $stable({lk_en, lk_vec, lk_pkd, lk_bank})));

    // R5: a slot without enabled set has been cleared
    p_clear_slot_r5: assert property (@(posedge clk) disable iff (rst)
        !lk_en |-> !(lk_vec || lk_pkd || lk_bank));

endmodule

bind regmap_builder regmap_builder_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rebuild (rebuild),
    .busy    (busy),
    .lk_fp   (lk_fp),
    .lk_idx  (lk_idx),
    .lk_en   (lk_en),
    .lk_vec  (lk_vec),
    .lk_pkd  (lk_pkd),
    .lk_bank (lk_bank)
);

// File: tb/regmap_builder_test.sv
module regmap_builder_test;

    localparam int NE = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [3:0] cfg_addr;
    logic [1:0] cfg_kind;
    logic [4:0] cfg_key;
    logic       cfg_vec, cfg_pkd, cfg_bank;
    logic       rebuild;
    logic       busy;
    logic       lk_fp;
    logic [4:0] lk_idx;
    logic       lk_en, lk_vec, lk_pkd, lk_bank;

    always #2 clk = ~clk;   // 250 MHz

    regmap_builder #(.NUM_ENTRIES(NE)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_kind(cfg_kind), .cfg_key(cfg_key), .cfg_vec(cfg_vec),
        .cfg_pkd(cfg_pkd), .cfg_bank(cfg_bank), .rebuild(rebuild),
        .busy(busy), .lk_fp(lk_fp), .lk_idx(lk_idx), .lk_en(lk_en),
        .lk_vec(lk_vec), .lk_pkd(lk_pkd), .lk_bank(lk_bank)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic       fp;
        logic [4:0] idx;
        logic [3:0] exp;
        string      req;
    } item_t;

    item_t sb[$];

    // entry: {kind[1:0], key[4:0], vec, pkd, bank}
    logic [9:0] st   [NE];
    logic [9:0] snap [NE];
    // slot: {en, vec, pkd, bank}
    logic [3:0] mt   [2][32];

    // monitor: compares one queued lookup per cycle
    always @(negedge clk) begin
        item_t it;
        logic [3:0] act;
        if (sb.size() > 0) begin
            it  = sb.pop_front();
            act = {lk_en, lk_vec, lk_pkd, lk_bank};
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s lookup fp=%0d idx=%0d got %b expected %b",
                         it.req, it.fp, it.idx, act, it.exp);
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_look(bit fp, int idx, string req);
        item_t it;
        lk_fp  = fp;
        lk_idx = 5'(idx);
        it.fp  = fp;
        it.idx = 5'(idx);
        it.exp = mt[fp][idx];
        it.req = req;
        sb.push_back(it);
    endtask

    // R12: each lookup is compared in the cycle its index is applied
    task automatic check_all(string req);
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 32; i++) begin
                @(posedge clk); #1;
                push_look(b[0], i, req);
            end
        end
        repeat (2) @(posedge clk);
    endtask

    task automatic set_wr(int a, int kind, int key, bit v, bit p, bit b);
        cfg_we   = 1'b1;
        cfg_addr = 4'(a);
        cfg_kind = 2'(kind);
        cfg_key  = 5'(key);
        cfg_vec  = v;
        cfg_pkd  = p;
        cfg_bank = b;
        st[a]    = {2'(kind), 5'(key), v, p, b};
    endtask

    task automatic wr(int a, int kind, int key, bit v, bit p, bit b);
        @(posedge clk); #1;
        set_wr(a, kind, key, v, p, b);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // expected tables from the captured list: clear, then ascending walk
    task automatic build_model();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 32; i++)
                mt[b][i] = 4'b0;
        for (int e = 0; e < NE; e++) begin
            mt[(snap[e][9:8] != 2'b00) ? 1 : 0][snap[e][7:3]] =
                {1'b1, snap[e][2], snap[e][1], snap[e][0]};
        end
    endtask

    task automatic run_rebuild(bit trig_write, bit mid_write, bit retrig);
        int k;
        @(posedge clk); #1;
        rebuild = 1'b1;
        for (int e = 0; e < NE; e++) snap[e] = st[e];
        if (trig_write) set_wr(13, 1, 20, 1'b1, 1'b1, 1'b1);   // R10
        @(posedge clk); #1;
        rebuild = 1'b0;
        cfg_we  = 1'b0;
        k = 0;
        while (busy === 1'b1 && k < 40) begin
            k++;
            cfg_we  = 1'b0;
            rebuild = 1'b0;
            if (mid_write && k == 3) set_wr(14, 0, 22, 1'b1, 1'b0, 1'b0);  // R10
            if (retrig && k == 5) rebuild = 1'b1;                            // R11
            push_look(k[0], (k * 7) % 32, "R9");
            @(posedge clk); #1;
        end
        cfg_we  = 1'b0;
        rebuild = 1'b0;
        chk(k == NE + 1, "R8 busy length", k, NE + 1);
        build_model();
        repeat (4) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R11 no second rebuild", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired got running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_kind = '0; cfg_key = '0;
        cfg_vec = 1'b0; cfg_pkd = 1'b0; cfg_bank = 1'b0; rebuild = 1'b0;
        lk_fp = 1'b0; lk_idx = '0;
        for (int e = 0; e < NE; e++) begin st[e] = '0; snap[e] = '0; end
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 32; i++) mt[b][i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check_all("R1");

        // list: int slot 3 named by entries 0 and 5 (R7), all type codes (R2)
        wr(0, 0, 3, 1'b1, 1'b0, 1'b0);
        wr(1, 1, 3, 1'b0, 1'b1, 1'b1);
        wr(2, 2, 31, 1'b1, 1'b1, 1'b0);
        wr(3, 3, 0, 1'b0, 1'b0, 1'b1);
        wr(4, 0, 31, 1'b0, 1'b1, 1'b0);
        wr(5, 0, 3, 1'b0, 1'b1, 1'b1);
        wr(6, 1, 17, 1'b1, 1'b0, 1'b1);
        wr(12, 0, 9, 1'b1, 1'b1, 1'b1);
        run_rebuild(1'b1, 1'b1, 1'b0);
        check_all("R2 R3 R4 R5 R7 R10");

        // second list: int slot 3 no longer named (R6), late writes now used (R10)
        wr(0, 1, 8, 1'b1, 1'b0, 1'b0);
        wr(5, 0, 10, 1'b0, 1'b0, 1'b1);
        wr(12, 0, 9, 1'b0, 1'b0, 1'b0);
        run_rebuild(1'b0, 1'b0, 1'b1);
        check_all("R6 R10 R11");

        // R7 across banks: same key, different banks both kept
        wr(7, 0, 25, 1'b1, 1'b0, 1'b0);
        wr(8, 2, 25, 1'b0, 1'b1, 1'b0);
        wr(9, 0, 25, 1'b0, 1'b0, 1'b1);
        run_rebuild(1'b0, 1'b0, 1'b0);
        check_all("R2 R7 R12");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule